// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Protection

This block guards a small processor against runaway code. A counter advances on ticks from one of three clock sources: the local clock divided by four, a low-speed RC tick, or a low-speed crystal tick. A 3-bit prescale field picks how many ticks are allowed before the watchdog expires. If the processor is running when the count expires, the block raises a one-cycle reset request. If the processor is halted, the block raises a one-cycle wake-up request instead. In both cases the time-out flag (TO) is set.

The processor restarts the counter with clear instructions, which reach the block as single-cycle pulses. A static strap selects one of two clear modes. In single mode, one clear instruction is enough. In paired mode, two different clear instructions must follow each other, which makes it unlikely that stray code restarts the watchdog by accident. A completed clear also drops TO and the power-down flag (PDF). A halt pulse sets PDF. A second strap turns the watchdog off altogether.

Top module: `wdt_guard`

## Requirements
- R1: After reset, sys_rst_o, wake_o, to_o and pdf_o are all 0.
- R2: With prescale field ctl_wdata_i[2:0] = n, expiry comes on the 2^(8+n)-th tick counted after the clock edge that completed the last clear.
- R3: Source field ctl_wdata_i[4:3]: 00 selects clk divided by 4, 01 selects lrc_tick_i, 10 selects lxt_tick_i, and 11 behaves like 01. The clk/4 divider restarts on a completed clear.
- R4: Expiry while running gives sys_rst_o high for exactly one cycle and sets to_o.
- R5: Expiry while halted gives wake_o for one cycle instead of sys_rst_o and sets to_o. The halted state then ends, so the next expiry gives sys_rst_o.
- R6: While halted, the clk/4 source produces no ticks and the count is held.
- R7: A halt_i pulse sets pdf_o on the next edge.
- R8: Single mode (cfg_pair = 0): a clr_one_i pulse clears the counter, to_o and pdf_o; clr_a_i and clr_b_i have no effect.
- R9: Paired mode (cfg_pair = 1): the counter, to_o and pdf_o clear only when a clr_a_i pulse and a clr_b_i pulse arrive one after the other, in either order. The same half twice in a row does not complete a clear, and clr_one_i is ignored.
- R10: Once a paired clear completes, the half it ended with is forgotten, so one further opposite half does not clear.
- R11: With cfg_en = 0, the counter is held at zero and no reset or wake-up request is raised.
- R12: to_o and pdf_o change only through expiry, halt, a completed clear or reset. Control-register writes leave them as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_en | input | 1 | Static strap, watchdog enabled |
| cfg_pair | input | 1 | Static strap, paired clear mode |
| clr_one_i | input | 1 | Single clear instruction pulse |
| clr_a_i | input | 1 | First-half clear instruction pulse |
| clr_b_i | input | 1 | Second-half clear instruction pulse |
| halt_i | input | 1 | Halt instruction pulse |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 5 | Control data: [2:0] prescale, [4:3] source |
| lrc_tick_i | input | 1 | Low-speed RC tick enable |
| lxt_tick_i | input | 1 | Low-speed crystal tick enable |
| sys_rst_o | output | 1 | Reset request pulse |
| wake_o | output | 1 | Wake-up request pulse |
| to_o | output | 1 | Time-out flag |
| pdf_o | output | 1 | Power-down flag |

## Verification
The hardest situation to reach is showing that the clk/4 source really freezes during halt. Halt can only be left by expiry or by a clear, and a clear would erase the count. The bench therefore builds a known partial count on the divided clock and halts the block. After a long quiet wait it switches the source to the always-ticking RC input. The wake-up must then arrive exactly after the remaining ticks, which proves no divided-clock ticks were lost or gained while halted. The paired-clear ordering is reached by putting repeated same-half pulses and an ignored single clear between genuine pairs, and checking that the expiry time still counts from the last real pair.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      SRC_SYSDIV = 2'b00,
      SRC_LRC    = 2'b01,
      SRC_LXT    = 2'b10,
      SRC_ALT    = 2'b11
   } wdt_src_e;

   typedef enum logic [1:0] {
      PEND_NONE = 2'b00,
      PEND_A    = 2'b01,
      PEND_B    = 2'b10
   } wdt_pend_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
   import wdt_pkg::*;
#(
   parameter int SYS_DIV = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  wdt_src_e src,
   input  logic     halted,
   input  logic     restart,
   input  logic     lrc_tick,
   input  logic     lxt_tick,
   output logic     tick
);
   logic sys_tick;

   if (SYS_DIV < 1) begin : g_bad_div
      $error("wdt_tick_gen: SYS_DIV must be at least 1");
   end

   if (SYS_DIV == 1) begin : g_nodiv
      assign sys_tick = ~halted;
   end else begin : g_div
      localparam int DIV_W = $clog2(SYS_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        div_q <= '0;
         else if (restart)  div_q <= '0;
         else if (!halted)  div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      end

      assign sys_tick = (div_q == DIV_LAST) & ~halted;
   end

   always_comb begin
      unique case (src)
         SRC_SYSDIV: tick = sys_tick;
         SRC_LXT:    tick = lxt_tick;
         default:    tick = lrc_tick;
      endcase
   end
endmodule

// File: rtl/wdt_clear_seq.sv
module wdt_clear_seq
   import wdt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pair_mode,
   input  logic clr_one,
   input  logic clr_a,
   input  logic clr_b,
   output logic done
);
   wdt_pend_e pend_q, pend_d;

   always_comb begin
      done   = 1'b0;
      pend_d = pend_q;
      if (!pair_mode) begin
         done   = clr_one;
         pend_d = PEND_NONE;
      end else if (clr_a ^ clr_b) begin
         if (clr_a) begin
            if (pend_q == PEND_B) begin
               done   = 1'b1;
               pend_d = PEND_NONE;
            end else begin
               pend_d = PEND_A;
            end
         end else begin
            if (pend_q == PEND_A) begin
               done   = 1'b1;
               pend_d = PEND_NONE;
            end else begin
               pend_d = PEND_B;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= PEND_NONE;
      else        pend_q <= pend_d;
   end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int BASE_EXP = 8,
   parameter int PRE_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic             tick,
   input  logic [PRE_W-1:0] pre,
   output logic             expire
);
   localparam int SPAN  = (1 << PRE_W) - 1;
   localparam int CNT_W = BASE_EXP + SPAN;

   if (BASE_EXP < 1 || PRE_W < 1 || PRE_W > 4) begin : g_bad_cfg
      $error("wdt_count: BASE_EXP >= 1 and 1 <= PRE_W <= 4 required");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   always_comb last = {CNT_W{1'b1}} >> (SPAN - int'(pre));

   assign expire = en & tick & ~restart & (cnt_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (!en || restart || expire)   cnt_q <= '0;
      else if (tick)                       cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_pkg::*;
#(
   parameter int BASE_EXP = 8,
   parameter int PRE_W    = 3,
   parameter int SYS_DIV  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_en,
   input  logic                cfg_pair,
   input  logic                clr_one_i,
   input  logic                clr_a_i,
   input  logic                clr_b_i,
   input  logic                halt_i,
   input  logic                ctl_we_i,
   input  logic [PRE_W+1:0]    ctl_wdata_i,
   input  logic                lrc_tick_i,
   input  logic                lxt_tick_i,
   output logic                sys_rst_o,
   output logic                wake_o,
   output logic                to_o,
   output logic                pdf_o
);
   localparam int CTL_W = PRE_W + 2;
   localparam logic [CTL_W-1:0] CTL_RST = {SRC_SYSDIV, {PRE_W{1'b1}}};

   logic [CTL_W-1:0] ctl_q;
   logic             halted;
   logic             clr_done;
   logic             tick;
   logic             expire;
   wdt_src_e         src;

   assign src = wdt_src_e'(ctl_q[CTL_W-1 -: 2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl_q <= CTL_RST;
      else if (ctl_we_i) ctl_q <= ctl_wdata_i;
   end

   wdt_clear_seq u_clr (
      .clk       (clk),
      .rst_n     (rst_n),
      .pair_mode (cfg_pair),
      .clr_one   (clr_one_i),
      .clr_a     (clr_a_i),
      .clr_b     (clr_b_i),
      .done      (clr_done)
   );

   wdt_tick_gen #(.SYS_DIV(SYS_DIV)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src),
      .halted   (halted),
      .restart  (clr_done),
      .lrc_tick (lrc_tick_i),
      .lxt_tick (lxt_tick_i),
      .tick     (tick)
   );

   wdt_count #(.BASE_EXP(BASE_EXP), .PRE_W(PRE_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_en),
      .restart (clr_done),
      .tick    (tick),
      .pre     (ctl_q[PRE_W-1:0]),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_rst_o <= 1'b0;
         wake_o    <= 1'b0;
         to_o      <= 1'b0;
         pdf_o     <= 1'b0;
         halted    <= 1'b0;
      end else begin
         sys_rst_o <= expire & ~halted;
         wake_o    <= expire & halted;
         halted    <= halt_i | (halted & ~clr_done & ~expire);
         if (clr_done)    to_o <= 1'b0;
         else if (expire) to_o <= 1'b1;
         if (halt_i)        pdf_o <= 1'b1;
         else if (clr_done) pdf_o <= 1'b0;
      end
   end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_en,
   input logic halt_i,
   input logic sys_rst_o,
   input logic wake_o,
   input logic to_o,
   input logic pdf_o,
   input logic halted,
   input logic clr_done
);
   a_r4_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> !sys_rst_o);

   a_r4_to_with_request: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_rst_o || wake_o) |-> to_o);

   a_r5_wake_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (!sys_rst_o && $past(halted)));

   a_r5_rst_only_running: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |-> !$past(halted));

   a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (!sys_rst_o && !wake_o));

   a_r12_to_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_o) |-> (sys_rst_o || wake_o));

   a_r12_to_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(to_o) |-> $past(clr_done));

   a_r7_pdf_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdf_o) |-> $past(halt_i));

   a_r12_pdf_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pdf_o) |-> $past(clr_done));
endmodule

bind wdt_guard wdt_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_en),
   .halt_i    (halt_i),
   .sys_rst_o (sys_rst_o),
   .wake_o    (wake_o),
   .to_o      (to_o),
   .pdf_o     (pdf_o),
   .halted    (halted),
   .clr_done  (clr_done)
);

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {source[1:0], prescale[2:0], expected cycles[19:0]}
   localparam logic [24:0] VEC [NVEC] = '{
      {2'd1, 3'd0, 20'd256},
      {2'd1, 3'd3, 20'd2048},
      {2'd2, 3'd1, 20'd512},
      {2'd0, 3'd0, 20'd1024},
      {2'd0, 3'd2, 20'd4096},
      {2'd3, 3'd0, 20'd256},
      {2'd1, 3'd7, 20'd32768},
      {2'd2, 3'd0, 20'd256}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b1;
   logic       cfg_pair = 1'b0;
   logic       clr_one_i = 1'b0;
   logic       clr_a_i = 1'b0;
   logic       clr_b_i = 1'b0;
   logic       halt_i = 1'b0;
   logic       ctl_we_i = 1'b0;
   logic [4:0] ctl_wdata_i = '0;
   logic       lrc_tick_i = 1'b1;
   logic       lxt_tick_i = 1'b1;
   logic       sys_rst_o, wake_o, to_o, pdf_o;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_guard uut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_pair(cfg_pair),
      .clr_one_i(clr_one_i), .clr_a_i(clr_a_i), .clr_b_i(clr_b_i),
      .halt_i(halt_i), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
      .lrc_tick_i(lrc_tick_i), .lxt_tick_i(lxt_tick_i),
      .sys_rst_o(sys_rst_o), .wake_o(wake_o), .to_o(to_o), .pdf_o(pdf_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [1:0] s, input logic [2:0] p);
      ctl_we_i = 1'b1; ctl_wdata_i = {s, p};
      step();
      ctl_we_i = 1'b0;
   endtask

   task automatic pulse_one();  clr_one_i = 1'b1; step(); clr_one_i = 1'b0; endtask
   task automatic pulse_a();    clr_a_i = 1'b1;   step(); clr_a_i = 1'b0;   endtask
   task automatic pulse_b();    clr_b_i = 1'b1;   step(); clr_b_i = 1'b0;   endtask
   task automatic pulse_halt(); halt_i = 1'b1;    step(); halt_i = 1'b0;    endtask

   // counts cycles until the wanted request; n = lim+1 when never seen
   task automatic measure(input bit want_wake, input int lim, output int n, output int other);
      other = 0;
      for (int k = 1; k <= lim; k++) begin
         step();
         if (want_wake ? wake_o : sys_rst_o) begin
            n = k;
            return;
         end
         if (want_wake ? sys_rst_o : wake_o) other++;
      end
      n = lim + 1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int n, oth;
      step();
      do_reset();
      // R1 reset state
      check({sys_rst_o, wake_o, to_o, pdf_o} == 4'b0000, "R1 reset outputs",
            {sys_rst_o, wake_o, to_o, pdf_o}, 0);

      // R2 R3 R4 table of sources and prescale settings (single mode)
      for (int i = 0; i < NVEC; i++) begin
         wr_ctl(VEC[i][24:23], VEC[i][22:20]);
         pulse_one();
         measure(1'b0, int'(VEC[i][19:0]) + 8, n, oth);
         check(n == int'(VEC[i][19:0]), "R2 R3 expiry cycles", n, int'(VEC[i][19:0]));
         check(oth == 0, "R4 no wake while running", oth, 0);
         if (i == 0) begin
            check(to_o == 1'b1, "R4 to set on expiry", to_o, 1);
            step();
            check(sys_rst_o == 1'b0, "R4 reset pulse one cycle", sys_rst_o, 0);
         end
      end

      // R12 control write does not touch flags; R8 halves ignored in single mode
      check(to_o == 1'b1, "R4 to held after expiry", to_o, 1);
      wr_ctl(2'd1, 3'd0);
      check(to_o == 1'b1, "R12 ctl write keeps to", to_o, 1);
      pulse_a(); pulse_b();
      check(to_o == 1'b1, "R8 halves ignored in single mode", to_o, 1);
      pulse_one();
      check(to_o == 1'b0, "R8 single clear drops to", to_o, 0);

      // R5 R7 expiry while halted
      pulse_one();
      pulse_halt();
      check(pdf_o == 1'b1, "R7 halt sets pdf", pdf_o, 1);
      measure(1'b1, 300, n, oth);
      check(n == 255, "R5 wake timing", n, 255);
      check(oth == 0, "R5 no reset while halted", oth, 0);
      check(to_o == 1'b1 && pdf_o == 1'b1, "R5 flags after wake", {to_o, pdf_o}, 3);
      measure(1'b0, 300, n, oth);
      check(n == 256 && oth == 0, "R5 halted state ends after wake", n, 256);

      // R6 divided clock frozen while halted
      wr_ctl(2'd0, 3'd0);
      pulse_one();
      repeat (400) step();
      pulse_halt();
      measure(1'b1, 3000, n, oth);
      check(n == 3001 && oth == 0, "R6 no ticks while halted", n, 3001);
      wr_ctl(2'd1, 3'd0);
      measure(1'b1, 300, n, oth);
      check(n == 156, "R6 held count resumes on RC source", n, 156);

      // R11 disabled watchdog
      cfg_en = 1'b0;
      wr_ctl(2'd1, 3'd0);
      measure(1'b0, 1000, n, oth);
      check(n == 1001 && oth == 0, "R11 no request when disabled", n, 1001);
      cfg_en = 1'b1;
      measure(1'b0, 300, n, oth);
      check(n == 256, "R11 counter held at zero", n, 256);

      // R3 crystal source follows its own tick
      lxt_tick_i = 1'b0;
      wr_ctl(2'd2, 3'd0);
      pulse_one();
      measure(1'b0, 600, n, oth);
      check(n == 601, "R3 crystal source idle without ticks", n, 601);
      lxt_tick_i = 1'b1;
      measure(1'b0, 300, n, oth);
      check(n == 256, "R3 crystal source counts its ticks", n, 256);

      // paired mode
      cfg_pair = 1'b1;
      do_reset();
      wr_ctl(2'd1, 3'd0);
      pulse_a(); pulse_b();
      repeat (98) step();
      pulse_a(); pulse_a(); pulse_one();
      measure(1'b0, 300, n, oth);
      check(n == 155, "R9 repeated half and single clear do not restart", n, 155);
      pulse_halt();
      pulse_a();
      check(to_o == 1'b1 && pdf_o == 1'b1, "R9 one half keeps flags", {to_o, pdf_o}, 3);
      pulse_a();
      check(to_o == 1'b1 && pdf_o == 1'b1, "R9 same half twice keeps flags", {to_o, pdf_o}, 3);
      pulse_b();
      check(to_o == 1'b0 && pdf_o == 1'b0, "R9 pair clears flags", {to_o, pdf_o}, 0);
      pulse_halt();
      pulse_b(); pulse_a();
      check(pdf_o == 1'b0, "R9 reverse order pair clears", pdf_o, 0);
      pulse_halt();
      pulse_b();
      check(pdf_o == 1'b1, "R10 half forgotten after completion", pdf_o, 1);
      pulse_a();
      check(pdf_o == 1'b0, "R10 fresh pair completes", pdf_o, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule